// File: doc/BRIEF.md
# Least-Recently-Used Bus Arbiter

This block decides which of several bus masters may drive a shared bus. It keeps a full recency ranking of every device. When the bus is free, it grants the bus to the requester that has gone longest without a turn. A device that has just been served drops to the bottom of the ranking, so no device keeps a fixed advantage. Every device that keeps requesting gets its turn.

The ranking is re-sorted only at tenure boundaries, never on every clock. A tenure lasts for a configurable number of bus-cycle strobes, and it ends early if the owning device withdraws its request. When a tenure ends, the next owner is chosen in that same cycle from the updated ranking. The grant is registered and appears on the following clock. No data passes through the block, so it has no valid/ready stream interface. Requests, the strobe and the grant are plain level signals with no back-pressure.

Top module: `lru_bus_arbiter`

## Requirements
- R1: During and after reset the grant is all zeros, and the ranking from oldest to newest is device 0, 1, 2, 3, so device 0 wins first.
- R2: While no grant is held, any request produces, on the next clock, a grant to the requesting device ranked oldest.
- R3: The grant is one-hot or zero, bit k meaning device k, and it only names a device whose request was high on the previous clock.
- R4: While its request stays high, the owner keeps the grant unchanged until TENURE_CYCLES strobes have been seen during the tenure; the grant may change only on the clock that takes the last of them.
- R5: If the owner drops its request, the tenure ends on that clock, and the grant moves to the next choice or to zero.
- R6: At every tenure end, the served device moves to the newest end of the ranking, and the devices that were newer than it each move one place older, keeping their relative order.
- R7: With no request pending, the grant is zero and the ranking does not change.
- R8: A request drop on the same clock as the final strobe ends the tenure once and updates the ranking once.
- R9: Under continuous requests from all devices, every device receives a grant within NUM_DEV consecutive tenures.
- R10: Strobes that arrive while no grant is held have no effect on the grant or the ranking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_DEV | Request level per device |
| bus_cycle_i | input | 1 | One-clock strobe per completed bus cycle |
| grant_o | output | NUM_DEV | One-hot bus grant, zero when idle |

## Verification
Two events can end a tenure on the same clock: the final counted strobe and a request drop by the owner. Both are also the clock on which the next owner is chosen. The bench forces the drop onto the strobe that would expire the tenure, then checks that the ranking moved by exactly one place. It does so by comparing every later grant with a queue-based model, because a double move would reorder the next winners. Random phases make the drop, the expiry and the new selection coincide many more times under mixed request patterns.

// File: rtl/lru_arb_pkg.sv
package lru_arb_pkg;
  function automatic int unsigned tenure_cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/lru_order_list.sv
module lru_order_list #(
  parameter int unsigned NUM_DEV = 4,
  localparam int unsigned ID_W = (NUM_DEV < 2) ? 1 : $clog2(NUM_DEV)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            move_en,
  input  logic [ID_W-1:0]                 served_id,
  output logic [NUM_DEV-1:0][ID_W-1:0]    rank_next,
  output logic [NUM_DEV-1:0][ID_W-1:0]    rank_q
);
  logic [NUM_DEV-1:0] hit;
  logic [NUM_DEV-1:0] at_or_after;
  logic [NUM_DEV-1:0][ID_W-1:0] moved;

  genvar i;
  generate
    for (i = 0; i < NUM_DEV; i++) begin : g_slot
      assign hit[i] = (rank_q[i] == served_id);
      if (i == 0) begin : g_first
        assign at_or_after[i] = hit[i];
      end else begin : g_rest
        assign at_or_after[i] = at_or_after[i-1] | hit[i];
      end
      if (i == NUM_DEV - 1) begin : g_newest
        assign moved[i] = served_id;
      end else begin : g_shift
        assign moved[i] = at_or_after[i] ? rank_q[i+1] : rank_q[i];
      end
    end
  endgenerate

  assign rank_next = move_en ? moved : rank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_DEV; k++) rank_q[k] <= ID_W'(k);
    end else begin
      rank_q <= rank_next;
    end
  end
endmodule

// File: rtl/lru_grant_pick.sv
module lru_grant_pick #(
  parameter int unsigned NUM_DEV = 4,
  localparam int unsigned ID_W = (NUM_DEV < 2) ? 1 : $clog2(NUM_DEV)
) (
  input  logic [NUM_DEV-1:0][ID_W-1:0] rank,
  input  logic [NUM_DEV-1:0]           req,
  output logic                         found,
  output logic [ID_W-1:0]              pick_id
);
  always_comb begin
    found   = 1'b0;
    pick_id = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (req[rank[i]]) begin
        found   = 1'b1;
        pick_id = rank[i];
      end
    end
  end
endmodule

// File: rtl/lru_tenure_timer.sv
module lru_tenure_timer #(
  parameter int unsigned TENURE_CYCLES = 4,
  localparam int unsigned CNT_W = lru_arb_pkg::tenure_cnt_width(TENURE_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == CNT_W'(TENURE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (tick && !last) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lru_bus_arbiter.sv
module lru_bus_arbiter #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned TENURE_CYCLES = 4,
  localparam int unsigned ID_W = (NUM_DEV < 2) ? 1 : $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] req_i,
  input  logic               bus_cycle_i,
  output logic [NUM_DEV-1:0] grant_o
);
  logic [NUM_DEV-1:0]           grant_q;
  logic [ID_W-1:0]              owner_q;
  logic                         busy;
  logic                         owner_left;
  logic                         last_cycle;
  logic                         tenure_end;
  logic                         choose;
  logic                         found;
  logic [ID_W-1:0]              pick_id;
  logic [NUM_DEV-1:0][ID_W-1:0] rank_next;
  logic [NUM_DEV-1:0][ID_W-1:0] rank_q;

  assign busy       = |grant_q;
  assign owner_left = !req_i[owner_q];
  assign tenure_end = busy && (owner_left || (bus_cycle_i && last_cycle));
  assign choose     = !busy || tenure_end;

  lru_order_list #(.NUM_DEV(NUM_DEV)) u_rank (
    .clk       (clk),
    .rst_n     (rst_n),
    .move_en   (tenure_end),
    .served_id (owner_q),
    .rank_next (rank_next),
    .rank_q    (rank_q)
  );

  lru_grant_pick #(.NUM_DEV(NUM_DEV)) u_pick (
    .rank    (rank_next),
    .req     (req_i),
    .found   (found),
    .pick_id (pick_id)
  );

  lru_tenure_timer #(.TENURE_CYCLES(TENURE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (choose),
    .tick    (bus_cycle_i && busy),
    .last    (last_cycle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      owner_q <= '0;
    end else if (choose) begin
      grant_q <= found ? (NUM_DEV'(1) << pick_id) : '0;
      owner_q <= pick_id;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/lru_arb_chk.sv
module lru_arb_chk #(
  parameter int unsigned NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] req_i,
  input logic               bus_cycle_i,
  input logic [NUM_DEV-1:0] grant_o
);
  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R3
  grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> (($past(req_i) & grant_o) != '0));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && ((req_i & grant_o) != '0) && !bus_cycle_i) |=> $stable(grant_o));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> (grant_o == '0));

  // R2
  idle_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o == '0) && (req_i != '0)) |=> (grant_o != '0));
endmodule

bind lru_bus_arbiter lru_arb_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .bus_cycle_i (bus_cycle_i),
  .grant_o     (grant_o)
);

// File: tb/lru_bus_arbiter_tb.sv
module lru_bus_arbiter_tb;
  localparam int N = 4;
  localparam int T = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         bus_cycle_i = 1'b0;
  logic [N-1:0] grant_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  int m_rank[$];
  int m_owner = -1;
  int m_cnt = 0;
  int seen[N];

  always #10 clk = ~clk;

  lru_bus_arbiter #(.NUM_DEV(N), .TENURE_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .bus_cycle_i(bus_cycle_i), .grant_o(grant_o)
  );

  function automatic logic [N-1:0] model_grant();
    return (m_owner < 0) ? '0 : (N'(1) << m_owner);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rank = {0, 1, 2, 3};
      m_owner = -1;
      m_cnt = 0;
    end else begin
      bit busy;
      bit ended;
      busy = (m_owner >= 0);
      ended = busy && (!req_i[m_owner] || (bus_cycle_i && m_cnt == T - 1));
      if (ended) begin
        foreach (m_rank[i]) if (m_rank[i] == m_owner) begin
          m_rank.delete(i);
          break;
        end
        m_rank.push_back(m_owner);
      end
      if (!busy || ended) begin
        m_owner = -1;
        m_cnt = 0;
        foreach (m_rank[i]) if (req_i[m_rank[i]]) begin
          m_owner = m_rank[i];
          break;
        end
        if (m_owner >= 0) seen[m_owner]++;
      end else if (bus_cycle_i) begin
        m_cnt++;
      end
    end
  end

  task automatic check(input string t, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grant actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, grant_o, model_grant());
      checks++;
      if (!$onehot0(grant_o)) begin
        fails++;
        $display("FAIL R3: grant actual %b expected one-hot or zero", grant_o);
      end
    end
  end

  task automatic step(input logic [N-1:0] r, input logic s);
    @(negedge clk);
    req_i = r;
    bus_cycle_i = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", grant_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", grant_o, '0);
    // R1 / R2: all request, device 0 wins first
    tag = "R2";
    step(4'b1111, 1'b0);
    @(negedge clk);
    check("R1", grant_o, 4'b0001);
    // R4 / R9: full tenures, all requesting
    tag = "R4";
    foreach (seen[i]) seen[i] = 0;
    repeat (4 * T * N) step(4'b1111, 1'b1);
    tag = "R9";
    foreach (seen[i]) begin
      checks++;
      if (seen[i] < 3) begin
        fails++;
        $display("FAIL R9: device %0d grants actual %0d expected >=3", i, seen[i]);
      end
    end
    // R4: strobes sparse, grant must hold
    tag = "R4";
    repeat (20) begin
      step(4'b1111, 1'b0);
      step(4'b1111, 1'b1);
    end
    // R5: owner drops early
    tag = "R5";
    step(4'b0100, 1'b0);
    repeat (T + 2) step(4'b0100, 1'b0);
    step(4'b1000, 1'b0);
    repeat (3) step(4'b1010, 1'b1);
    // R8: drop coincides with final strobe
    tag = "R8";
    step(4'b0000, 1'b0);
    step(4'b0001, 1'b0);
    repeat (T - 1) step(4'b0001, 1'b1);
    step(4'b0000, 1'b1);
    repeat (6) step(4'b1111, 1'b1);
    // R7 / R10: idle with strobes
    tag = "R10";
    repeat (8) step(4'b0000, 1'b1);
    tag = "R7";
    repeat (4) step(4'b0000, 1'b0);
    tag = "R6";
    repeat (3 * T * N) step(4'b1111, 1'b1);
    // R6 / R3: random mix
    tag = "R6";
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r;
      r = N'($urandom_range(0, 15));
      step(r, 1'($urandom_range(0, 1)));
    end
    step('0, 1'b0);
    @(negedge clk);
    finish_run();
  end
endmodule